// File: doc/BRIEF.md
# Bus-to-Slow-Clock Register Sync with Key Unlock

This block carries register writes from a fast bus clock domain into a slow oscillator domain of about 32 kHz. Each bus write to a data word lands at once in a bus-side shadow copy. A single toggle-handshake channel then ships it to the slow-domain copy. A pending register lets software poll for completion, so it can act as a fence. Every protected write is refused until a two-word key sequence has opened the block.

A control bit sets whether shadow transfers may start on slow clock boundaries. While that bit is clear, writes collect in the shadows and stay pending. A reload command goes the other way. It takes a snapshot of the slow-domain words and copies it into the bus view, so changes made by slow-side logic become visible on the bus. The slow-domain words stand in for the counter and alarm state of a real-time clock. They can be updated from the slow side through a simple update port.

The bus side sees eight data words at byte offsets 0x30 to 0x4C. The control word is at 0x50, the pending word at 0x68, and the two key words at 0x70 and 0x74. Reads are combinational from the read address.

Top module: `osc_sync_regbank`

## Requirements
- R1: After reset the block is locked. The control word (0x50), the pending word (0x68), all eight data words and all eight slow-domain words read zero.
- R2: A write of 0x83E70B13 to the first key (0x70), followed by a write of 0x95A4F1E0 to the second key (0x74), unlocks the block. Bit 23 of the control word then reads 1.
- R3: The block stays locked if the second key is written first, or if either key gets a different value. Any write of a non-magic value to the first key relocks an unlocked block and clears bit 23.
- R4: While locked, writes to the data words, to the control word and to the reload bit are dropped. The data words read back unchanged, the slow-domain words do not change, and the pending word stays zero.
- R5: Control bit 21 is the transfer enable. When the block is unlocked, a write to the control word sets or clears bit 21, and bit 21 reads back.
- R6: An unlocked write to a data word reads back from the next cycle on. Pending bit 0 reads 1 from the cycle after the write. Pending bit 0 returns to 0 only once the slow-domain word holds the written value.
- R7: While bit 21 is 0, data writes update the bus view, but no transfer starts. Pending bit 0 stays 1 and the slow-domain words stay unchanged until bit 21 is set.
- R8: Repeated writes to the same word while its transfer is in flight are not lost. Writes to several words all arrive. After the fence, each slow-domain word holds the last value written to it.
- R9: An unlocked write with bit 31 set to the pending word (0x68) requests a reload. Pending bit 1 reads 1 from the next cycle until the reload has finished. The data words then read back the slow-domain values, including values changed from the slow side. A reload and a write transfer are never in flight together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Bus-domain synchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Combinational read data |
| slow_clk | input | 1 | Slow oscillator clock |
| slow_rst_n | input | 1 | Slow-domain synchronous active-low reset |
| slow_upd_en | input | 1 | Slow-side update strobe for a slow-domain word |
| slow_upd_idx | input | 3 | Index of the slow-domain word to update |
| slow_upd_data | input | 32 | Slow-side update value |
| slow_regs_o | output | 256 | Slow-domain words, word i at bits 32*i+31 down to 32*i |

## Verification
Some internal faults show at the ports within one bus cycle. A lock flag in the wrong state, or a dirty bit set wrongly, shows up in the control or pending readback on the very next cycle. A transfer that carries the wrong index or stale data can only be seen once the handshake has finished, a few slow cycles later. At that point the slow-domain word differs from the last bus write. The slow words are compared on every bus clock whenever nothing should be in flight, so a transfer that starts when it should not shows up in the cycle it lands. A broken handshake leaves pending bits set, and the fence timeout in the bench catches it.

// File: rtl/osc_sync_pkg.sv
// Shared offsets, bit positions and key values for the bus-to-slow register sync.
package osc_sync_pkg;
    localparam int unsigned AW = 8;
    localparam int unsigned DW = 32;

    localparam logic [AW-1:0] OFS_DATA0 = 8'h30;
    localparam logic [AW-1:0] OFS_CTRL  = 8'h50;
    localparam logic [AW-1:0] OFS_PEND  = 8'h68;
    localparam logic [AW-1:0] OFS_KEYA  = 8'h70;
    localparam logic [AW-1:0] OFS_KEYB  = 8'h74;

    localparam int unsigned CTRL_XFER_EN_BIT = 21;
    localparam int unsigned CTRL_OPEN_BIT    = 23;
    localparam int unsigned PEND_WR_BIT      = 0;
    localparam int unsigned PEND_RL_BIT      = 1;
    localparam int unsigned PEND_RELOAD_CMD  = 31;

    localparam logic [DW-1:0] KEYA_MAGIC = 32'h83E7_0B13;
    localparam logic [DW-1:0] KEYB_MAGIC = 32'h95A4_F1E0;
endpackage

// File: rtl/osc_sync_bit_sync.sv
// Multi-flop synchronizer for one level or toggle signal.
// Assumes: d changes at most once per few destination clocks (toggle protocol).
module osc_sync_bit_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/osc_sync_key_gate.sv
// Two-word key sequence that opens protected writes.
// Assumes: a write to key A with its magic arms; the next key B write with its magic opens.
// A non-magic key A write closes the gate again.
module osc_sync_key_gate
    import osc_sync_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          unlocked
);
    logic armed;

    // Track the arm step and the open state from key writes only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed    <= 1'b0;
            unlocked <= 1'b0;
        end else if (wr_en && wr_addr == OFS_KEYA) begin
            armed <= (wr_data == KEYA_MAGIC);
            if (wr_data != KEYA_MAGIC) unlocked <= 1'b0;
        end else if (wr_en && wr_addr == OFS_KEYB) begin
            armed <= 1'b0;
            if (armed && wr_data == KEYB_MAGIC) unlocked <= 1'b1;
        end
    end
endmodule

// File: rtl/osc_sync_slow_bank.sv
// Slow-domain word bank: accepts shipped writes, serves reload snapshots.
// Assumes: wr_idx/wr_data are held stable by the bus side from request toggle until
// the acknowledge toggle returns; slow-side updates lose to a shipped write to the same word.
module osc_sync_slow_bank #(
    parameter int unsigned NUM_WORDS = 8,
    parameter int unsigned DW        = 32,
    parameter int unsigned IW        = 3
) (
    input  logic                    slow_clk,
    input  logic                    slow_rst_n,
    input  logic                    wr_req_tgl,
    input  logic [IW-1:0]           wr_idx,
    input  logic [DW-1:0]           wr_data,
    input  logic                    rl_req_tgl,
    input  logic                    upd_en,
    input  logic [IW-1:0]           upd_idx,
    input  logic [DW-1:0]           upd_data,
    output logic                    wr_ack_tgl,
    output logic                    rl_ack_tgl,
    output logic [NUM_WORDS*DW-1:0] regs_flat,
    output logic [NUM_WORDS*DW-1:0] snap_flat
);
    logic          wr_req_s, rl_req_s, wr_go, rl_go;
    logic [DW-1:0] regs [NUM_WORDS];
    logic [DW-1:0] snap [NUM_WORDS];

    osc_sync_bit_sync #(.STAGES(2)) u_wr_req_sync (
        .clk(slow_clk), .rst_n(slow_rst_n), .d(wr_req_tgl), .q(wr_req_s));
    osc_sync_bit_sync #(.STAGES(2)) u_rl_req_sync (
        .clk(slow_clk), .rst_n(slow_rst_n), .d(rl_req_tgl), .q(rl_req_s));

    assign wr_go = wr_req_s != wr_ack_tgl;
    assign rl_go = rl_req_s != rl_ack_tgl;

    // Apply slow-side updates, then shipped writes, and acknowledge each shipment.
    always_ff @(posedge slow_clk) begin
        if (!slow_rst_n) begin
            for (int i = 0; i < NUM_WORDS; i++) regs[i] <= '0;
            wr_ack_tgl <= 1'b0;
        end else begin
            if (upd_en) regs[upd_idx] <= upd_data;
            if (wr_go) begin
                regs[wr_idx] <= wr_data;
                wr_ack_tgl   <= ~wr_ack_tgl;
            end
        end
    end

    // Freeze a snapshot for a reload request and acknowledge it.
    always_ff @(posedge slow_clk) begin
        if (!slow_rst_n) begin
            for (int i = 0; i < NUM_WORDS; i++) snap[i] <= '0;
            rl_ack_tgl <= 1'b0;
        end else if (rl_go) begin
            for (int i = 0; i < NUM_WORDS; i++) snap[i] <= regs[i];
            rl_ack_tgl <= ~rl_ack_tgl;
        end
    end

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_flat
        assign regs_flat[g*DW +: DW] = regs[g];
        assign snap_flat[g*DW +: DW] = snap[g];
    end
endmodule

// File: rtl/osc_sync_regbank.sv
// Bus-side register bank with shadow words, a toggle-handshake transfer channel,
// a reload channel and a key gate. Top of the block.
// Assumes: slow_clk is much slower than clk; one transfer at a time, lowest dirty word first;
// a reload starts only when no write is dirty or in flight, and writes wait while a reload runs.
module osc_sync_regbank
    import osc_sync_pkg::*;
#(
    parameter int unsigned NUM_WORDS = 8,
    localparam int unsigned IW       = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [DW-1:0]           wr_data,
    input  logic [AW-1:0]           rd_addr,
    output logic [DW-1:0]           rd_data,
    input  logic                    slow_clk,
    input  logic                    slow_rst_n,
    input  logic                    slow_upd_en,
    input  logic [IW-1:0]           slow_upd_idx,
    input  logic [DW-1:0]           slow_upd_data,
    output logic [NUM_WORDS*DW-1:0] slow_regs_o
);
    localparam logic [AW-1:0] SPAN = AW'(4 * NUM_WORDS);

    logic                    unlocked, xfer_en;
    logic [DW-1:0]           shadow [NUM_WORDS];
    logic [NUM_WORDS*DW-1:0] shadow_flat, snap_flat;
    logic [NUM_WORDS-1:0]    dirty;
    logic                    xfer_busy, xfer_tgl, xfer_ack_s, xfer_ack_raw;
    logic [IW-1:0]           xfer_idx, pick_idx;
    logic [DW-1:0]           xfer_data;
    logic                    rl_req, rl_busy, rl_tgl, rl_ack_s, rl_ack_raw;
    logic [AW-1:0]           wr_off, rd_off;
    logic                    wr_data_hit, rd_data_hit, wr_allowed;
    logic                    launch, xfer_done, rl_launch, rl_done, write_pend;

    osc_sync_key_gate u_key (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .unlocked(unlocked));

    // Address decode for the data window.
    assign wr_off      = wr_addr - OFS_DATA0;
    assign rd_off      = rd_addr - OFS_DATA0;
    assign wr_data_hit = (wr_addr >= OFS_DATA0) && (wr_off < SPAN) && (wr_addr[1:0] == 2'b00);
    assign rd_data_hit = (rd_addr >= OFS_DATA0) && (rd_off < SPAN) && (rd_addr[1:0] == 2'b00);
    assign wr_allowed  = wr_en && unlocked;

    // Lowest-index dirty word is shipped first.
    always_comb begin
        pick_idx = '0;
        for (int i = NUM_WORDS - 1; i >= 0; i--) if (dirty[i]) pick_idx = IW'(i);
    end

    assign xfer_done  = xfer_busy && (xfer_ack_s == xfer_tgl);
    assign rl_done    = rl_busy && (rl_ack_s == rl_tgl);
    assign launch     = !xfer_busy && !rl_busy && xfer_en && (|dirty);
    assign rl_launch  = rl_req && !rl_busy && !xfer_busy && (dirty == '0);
    assign write_pend = (|dirty) || xfer_busy;

    // Control word: transfer enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 xfer_en <= 1'b0;
        else if (wr_allowed && wr_addr == OFS_CTRL) xfer_en <= wr_data[CTRL_XFER_EN_BIT];
    end

    // Shadow words and their dirty marks; reload fills only clean words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_WORDS; i++) shadow[i] <= '0;
            dirty <= '0;
        end else begin
            if (launch) dirty[pick_idx] <= 1'b0;
            if (rl_done)
                for (int i = 0; i < NUM_WORDS; i++)
                    if (!dirty[i]) shadow[i] <= snap_flat[i*DW +: DW];
            if (wr_allowed && wr_data_hit) begin
                shadow[wr_off[IW+1:2]] <= wr_data;
                dirty[wr_off[IW+1:2]]  <= 1'b1;
            end
        end
    end

    // Write channel: hold index and data stable while the toggle is outstanding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_busy <= 1'b0;
            xfer_tgl  <= 1'b0;
            xfer_idx  <= '0;
            xfer_data <= '0;
        end else if (launch) begin
            xfer_busy <= 1'b1;
            xfer_tgl  <= ~xfer_tgl;
            xfer_idx  <= pick_idx;
            xfer_data <= shadow[pick_idx];
        end else if (xfer_done) begin
            xfer_busy <= 1'b0;
        end
    end

    // Reload channel: request flag, then one toggle round trip.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rl_req  <= 1'b0;
            rl_busy <= 1'b0;
            rl_tgl  <= 1'b0;
        end else begin
            if (rl_launch) begin
                rl_req  <= 1'b0;
                rl_busy <= 1'b1;
                rl_tgl  <= ~rl_tgl;
            end else if (rl_done) begin
                rl_busy <= 1'b0;
            end
            if (wr_allowed && wr_addr == OFS_PEND && wr_data[PEND_RELOAD_CMD]) rl_req <= 1'b1;
        end
    end

    osc_sync_bit_sync #(.STAGES(2)) u_xfer_ack_sync (
        .clk(clk), .rst_n(rst_n), .d(xfer_ack_raw), .q(xfer_ack_s));
    osc_sync_bit_sync #(.STAGES(2)) u_rl_ack_sync (
        .clk(clk), .rst_n(rst_n), .d(rl_ack_raw), .q(rl_ack_s));

    osc_sync_slow_bank #(.NUM_WORDS(NUM_WORDS), .DW(DW), .IW(IW)) u_slow (
        .slow_clk(slow_clk), .slow_rst_n(slow_rst_n),
        .wr_req_tgl(xfer_tgl), .wr_idx(xfer_idx), .wr_data(xfer_data),
        .rl_req_tgl(rl_tgl),
        .upd_en(slow_upd_en), .upd_idx(slow_upd_idx), .upd_data(slow_upd_data),
        .wr_ack_tgl(xfer_ack_raw), .rl_ack_tgl(rl_ack_raw),
        .regs_flat(slow_regs_o), .snap_flat(snap_flat));

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_shadow_flat
        assign shadow_flat[g*DW +: DW] = shadow[g];
    end

    // Read mux.
    always_comb begin
        rd_data = '0;
        if (rd_data_hit) begin
            rd_data = shadow[rd_off[IW+1:2]];
        end else if (rd_addr == OFS_CTRL) begin
            rd_data[CTRL_XFER_EN_BIT] = xfer_en;
            rd_data[CTRL_OPEN_BIT]    = unlocked;
        end else if (rd_addr == OFS_PEND) begin
            rd_data[PEND_WR_BIT] = write_pend;
            rd_data[PEND_RL_BIT] = rl_req || rl_busy;
        end
    end
endmodule

// File: rtl/osc_sync_checker.sv
// Temporal checks on the bus side of the register sync; attached by bind.
// Assumes: the bound signals are the top's lock flag, enable, channel busy flags and shadow view.
module osc_sync_checker
    import osc_sync_pkg::*;
#(
    parameter int unsigned NUM_WORDS = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_en,
    input logic [AW-1:0]           wr_addr,
    input logic [DW-1:0]           wr_data,
    input logic                    unlocked,
    input logic                    xfer_en,
    input logic                    xfer_busy,
    input logic                    rl_busy,
    input logic                    write_pend,
    input logic [NUM_WORDS*DW-1:0] shadow_flat
);
    logic in_window;
    assign in_window = (wr_addr >= OFS_DATA0) && (wr_addr < OFS_DATA0 + AW'(4 * NUM_WORDS))
                       && (wr_addr[1:0] == 2'b00);

    assert_open_after_keyb_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(wr_en && wr_addr == OFS_KEYB && wr_data == KEYB_MAGIC));

    assert_locked_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !unlocked && in_window && !rl_busy) |=> $stable(shadow_flat));

    assert_pend_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && unlocked && in_window) |=> write_pend);

    assert_no_launch_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_en && !xfer_busy) |=> !xfer_busy);

    assert_channels_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(xfer_busy && rl_busy));
endmodule

bind osc_sync_regbank osc_sync_checker #(.NUM_WORDS(NUM_WORDS)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .unlocked(unlocked), .xfer_en(xfer_en), .xfer_busy(xfer_busy), .rl_busy(rl_busy),
    .write_pend(write_pend), .shadow_flat(shadow_flat));

// File: tb/osc_sync_regbank_bench.sv
`timescale 1ns/1ps
module osc_sync_regbank_bench;
    localparam int NW = 8;

    logic          clk = 1'b0, slow_clk = 1'b0;
    logic          rst_n = 1'b0, slow_rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_addr = '0, rd_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [31:0]   rd_data;
    logic          slow_upd_en = 1'b0;
    logic [2:0]    slow_upd_idx = '0;
    logic [31:0]   slow_upd_data = '0;
    logic [NW*32-1:0] slow_regs_o;

    int checks = 0, fails = 0;
    bit done = 1'b0, mon_en = 1'b0;

    // Reference model state
    bit          m_unl = 0, m_armed = 0, m_en = 0;
    logic [31:0] m_shadow [NW];
    logic [31:0] exp_slow [NW];

    always #2  clk = ~clk;
    always #31 slow_clk = ~slow_clk;

    osc_sync_regbank u_osc_sync_regbank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .slow_clk(slow_clk), .slow_rst_n(slow_rst_n),
        .slow_upd_en(slow_upd_en), .slow_upd_idx(slow_upd_idx), .slow_upd_data(slow_upd_data),
        .slow_regs_o(slow_regs_o));

    function automatic logic [31:0] exp_ctrl();
        logic [31:0] v = '0;
        v[23] = m_unl;
        v[21] = m_en;
        return v;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        rd_addr = a;
        #1;
        chk(rd_data === exp, tag, rd_data, exp);
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a == 8'h70) begin
            if (d == 32'h83E70B13) m_armed = 1;
            else begin m_armed = 0; m_unl = 0; end
        end else if (a == 8'h74) begin
            if (m_armed && d == 32'h95A4F1E0) m_unl = 1;
            m_armed = 0;
        end else if (m_unl) begin
            if (a == 8'h50) m_en = d[21];
            else if (a >= 8'h30 && a <= 8'h4C && a[1:0] == 2'b00) m_shadow[(a - 8'h30) >> 2] = d;
        end
    endtask

    task automatic fence(input logic [31:0] mask, input string tag);
        int n = 0;
        bit clear = 0;
        while (!clear && n < 3000) begin
            @(negedge clk);
            rd_addr = 8'h68;
            #1;
            clear = ((rd_data & mask) == 0);
            n++;
        end
        chk(clear, tag, rd_data & mask, 32'h0);
    endtask

    task automatic slow_update(input int idx, input logic [31:0] d);
        mon_en = 0;
        @(negedge slow_clk);
        slow_upd_en = 1'b1; slow_upd_idx = 3'(idx); slow_upd_data = d;
        @(negedge slow_clk);
        slow_upd_en = 1'b0;
        exp_slow[idx] = d;
        mon_en = 1;
    endtask

    // Per-clock comparison of the slow-domain words with the model while nothing is in flight.
    always @(negedge clk) begin
        if (mon_en && rst_n) begin
            for (int i = 0; i < NW; i++) begin
                checks++;
                if (slow_regs_o[i*32 +: 32] !== exp_slow[i]) begin
                    fails++;
                    $display("FAIL R6 slow word %0d actual=%h expected=%h",
                             i, slow_regs_o[i*32 +: 32], exp_slow[i]);
                end
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NW; i++) begin m_shadow[i] = '0; exp_slow[i] = '0; end
        repeat (40) @(negedge clk);
        rst_n = 1'b1; slow_rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: reset state
        rd_chk(8'h50, 32'h0, "R1 control");
        rd_chk(8'h68, 32'h0, "R1 pending");
        for (int i = 0; i < NW; i++) rd_chk(8'(8'h30 + 4*i), 32'h0, "R1 data word");
        mon_en = 1;

        // R4: locked writes are dropped
        bus_wr(8'h30, 32'h1111_1111);
        rd_chk(8'h30, m_shadow[0], "R4 locked data write");
        rd_chk(8'h68, 32'h0, "R4 pending after locked write");
        bus_wr(8'h50, 32'h0020_0000);
        rd_chk(8'h50, exp_ctrl(), "R4 locked control write");
        bus_wr(8'h68, 32'h8000_0000);
        rd_chk(8'h68, 32'h0, "R4 locked reload");
        repeat (40) @(negedge clk);

        // R3: reversed order and wrong values
        bus_wr(8'h74, 32'h95A4_F1E0);
        bus_wr(8'h70, 32'h83E7_0B13);
        rd_chk(8'h50, exp_ctrl(), "R3 reversed order");
        bus_wr(8'h70, 32'h1234_5678);
        bus_wr(8'h74, 32'h95A4_F1E0);
        rd_chk(8'h50, exp_ctrl(), "R3 wrong first key");
        bus_wr(8'h70, 32'h83E7_0B13);
        bus_wr(8'h74, 32'h95A4_F1E1);
        rd_chk(8'h50, exp_ctrl(), "R3 wrong second key");

        // R2: correct sequence
        bus_wr(8'h70, 32'h83E7_0B13);
        bus_wr(8'h74, 32'h95A4_F1E0);
        rd_chk(8'h50, 32'h0080_0000, "R2 unlock bit 23");

        // R7: transfer enable off holds writes in the shadow
        bus_wr(8'h38, 32'hA5A5_0002);
        rd_chk(8'h38, 32'hA5A5_0002, "R7 bus view updated");
        rd_chk(8'h68, 32'h1, "R7 pending held");
        repeat (80) @(negedge clk);
        rd_chk(8'h68, 32'h1, "R7 pending still held");

        // R5: enable bit readback, then the held write drains
        mon_en = 0;
        bus_wr(8'h50, 32'h0020_0000);
        rd_chk(8'h50, 32'h00A0_0000, "R5 enable readback");
        fence(32'h1, "R7 drain after enable");
        exp_slow[2] = m_shadow[2];
        mon_en = 1;

        // R6: single write round trip
        mon_en = 0;
        bus_wr(8'h44, 32'hC0DE_0005);
        rd_chk(8'h68, 32'h1, "R6 pending set");
        rd_chk(8'h44, 32'hC0DE_0005, "R6 bus readback");
        fence(32'h1, "R6 fence");
        exp_slow[5] = m_shadow[5];
        mon_en = 1;

        // R8: repeated writes to one word plus other words
        mon_en = 0;
        bus_wr(8'h34, 32'h0000_0A01);
        bus_wr(8'h34, 32'h0000_0A02);
        bus_wr(8'h4C, 32'h7777_0007);
        bus_wr(8'h34, 32'h0000_0A03);
        bus_wr(8'h30, 32'h5555_0000);
        fence(32'h1, "R8 fence");
        for (int i = 0; i < NW; i++) exp_slow[i] = m_shadow[i];
        @(negedge clk);
        chk(slow_regs_o[1*32 +: 32] === 32'h0000_0A03, "R8 last write wins",
            slow_regs_o[1*32 +: 32], 32'h0000_0A03);
        chk(slow_regs_o[7*32 +: 32] === 32'h7777_0007, "R8 other word arrives",
            slow_regs_o[7*32 +: 32], 32'h7777_0007);
        mon_en = 1;

        // R9: reload brings slow-side changes into the bus view
        slow_update(3, 32'hDEAD_0003);
        slow_update(5, 32'hBEEF_0005);
        rd_chk(8'h3C, 32'h0, "R9 before reload");
        bus_wr(8'h68, 32'h8000_0000);
        rd_chk(8'h68, 32'h2, "R9 reload pending");
        fence(32'h3, "R9 fence");
        for (int i = 0; i < NW; i++) begin
            m_shadow[i] = exp_slow[i];
            rd_chk(8'(8'h30 + 4*i), m_shadow[i], "R9 reloaded word");
        end

        // R3: relock by a non-magic first key, then R4 drop again
        bus_wr(8'h70, 32'h0);
        rd_chk(8'h50, exp_ctrl(), "R3 relock");
        bus_wr(8'h30, 32'hFFFF_FFFF);
        rd_chk(8'h30, m_shadow[0], "R4 drop after relock");
        rd_chk(8'h68, 32'h0, "R4 no pending after relock");
        repeat (80) @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule